// File: doc/BRIEF.md
# Serial Clock-Calendar Register Slave

This block is the device side of a three-wire serial link into a clock-calendar register bank. A host raises the active-high chip enable and clocks in a command byte. The command byte says whether the host reads or writes, and it names one register or the whole clock bank. One data byte follows, or a burst of eight bytes. The bank holds seven BCD time and date registers and a control register. Bit 7 of the control register is a write-protect flag. The block enforces that flag on every host write that targets a time register. A parallel load port lets an external timekeeping counter refresh the time registers, and the current time is available on a parallel output.

The serial pins are brought into the system clock domain through synchronizers, and their edges are detected there. Bytes travel least-significant bit first. Input bits are taken on rising serial-clock edges. Read data changes only after falling edges.

The transfer state machine has five states:
- `ST_IDLE`: chip enable is low.
- `ST_CMD`: the command byte is being collected.
- `ST_WDATA`: write data is arriving.
- `ST_RDATA`: read data is being shifted out.
- `ST_SKIP`: serial clocks are ignored until chip enable drops.

It makes these transitions:
- IDLE→CMD when enable rises.
- CMD→WDATA on a valid write command.
- CMD→RDATA on a valid read command.
- CMD→SKIP when the marker bit of the command is clear.
- WDATA→WDATA and RDATA→RDATA while a burst has bytes left.
- WDATA→SKIP and RDATA→SKIP after the last byte.
- Any state→IDLE when enable drops.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the time registers read seconds 00, minutes 00, hours 00, date 01, month 01, weekday 01, year 00, and the control register reads 0x80, so write-protect is set.
- R2: The command byte is sent LSB first. Bit 7 must be 1, bits 6:1 are the address, and bit 0 is 1 for read and 0 for write. A command with bit 7 clear makes the rest of that enable window have no effect: no write happens and sdo_oe stays low.
- R3: A read drives data LSB first. Bit 0 appears after the first falling serial-clock edge after the command byte, and each later bit appears after the next falling edge. sdo_oe is high only during the read-data phase.
- R4: With write-protect clear, a single-byte write to address 0 to 6 stores the byte in that time register. The map is: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year.
- R5: With write-protect set, host writes to time registers are ignored, in single-byte mode and inside a burst.
- R6: Writes to the control register (address 7) are always accepted. Bit 7 is stored as write-protect, and bits 6:0 always read as zero.
- R7: A write to address 0x1F is a burst. Eight data bytes go to registers 0 through 7 in ascending order, and the control byte comes last.
- R8: A read of address 0x1F returns registers 0 through 7 in ascending order. The values come from a snapshot taken when the command is decoded. The host may end a burst read early.
- R9: Dropping chip enable at any point aborts the transfer and discards a partial byte. The next transfer starts with a fresh command byte.
- R10: When ld_en is high, the load port writes ld_time into time registers 0 to 6 on the next clock, whatever the write-protect state. An accepted host write to the same register in the same cycle wins over the load.
- R11: Addresses other than 0 to 7 and 0x1F read as 0x00, and writes to them have no effect.
- R12: After a single-byte transfer or a full burst, further serial clocks in the same enable window write nothing and leave sdo_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Serial chip enable, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for sdo |
| ld_en | input | 1 | Parallel load strobe from timekeeping counter |
| ld_time | input | 56 | Load values, byte i for time register i |
| time_regs | output | 56 | Current time registers, byte i is register i |
| wp_out | output | 1 | Current write-protect flag |

## Verification
The assertions assume that the serial clock is slow compared with the system clock. Each half period must be longer than the synchronizer plus edge-detect latency. They also assume that sdi is stable around each rising serial edge. The stimulus meets these conditions by holding each serial level for eight system cycles and by changing sdi only while sclk is low. The load strobe is held for whole system cycles, and it is driven only on falling system-clock edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_REGS   = 8;
    localparam int NUM_TIME   = 7;
    localparam int ADDR_W     = 6;
    localparam int CTRL_IDX   = 7;
    localparam int WP_BIT     = 7;
    localparam logic [ADDR_W-1:0] BURST_ADDR = 6'h1F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } xfer_state_e;

    // Power-on contents: date, month and weekday start at 1, control has protect set.
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        case (idx)
            3, 4, 5:  return 8'h01;
            CTRL_IDX: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_serial_rx.sv
module rtc_serial_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    localparam int CNT_W      = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              ce_s,
    output logic              fall,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    logic [SYNC_STAGES-1:0] ce_sync, sclk_sync, sdi_sync;
    logic                   sclk_prev;
    logic [BYTE_W-1:0]      shreg;
    logic                   sclk_s, sdi_s, rise;

    assign ce_s   = ce_sync[SYNC_STAGES-1];
    assign sclk_s = sclk_sync[SYNC_STAGES-1];
    assign sdi_s  = sdi_sync[SYNC_STAGES-1];
    assign rise   = sclk_s & ~sclk_prev;
    assign fall   = ~sclk_s & sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_sync   <= '0;
            sclk_sync <= '0;
            sdi_sync  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            ce_sync   <= {ce_sync[SYNC_STAGES-2:0], ce_i};
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
            sdi_sync  <= {sdi_sync[SYNC_STAGES-2:0], sdi_i};
            sclk_prev <= sclk_s;
        end
    end

    // Bit and byte counting; everything clears while enable is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else if (!ce_s) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                shreg <= {sdi_s, shreg[BYTE_W-1:1]};
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    bit_cnt   <= '0;
                    byte_val  <= {sdi_s, shreg[BYTE_W-1:1]};
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank #(
    parameter int NUM_REGS = rtc_pkg::NUM_REGS,
    parameter int NUM_TIME = rtc_pkg::NUM_TIME,
    parameter int BYTE_W   = rtc_pkg::BYTE_W,
    parameter int CTRL_IDX = rtc_pkg::CTRL_IDX,
    parameter int WP_BIT   = rtc_pkg::WP_BIT,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       ld_en,
    input  logic [NUM_TIME*BYTE_W-1:0] ld_time,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
    output logic                       wp
);
    localparam logic [BYTE_W-1:0] WP_MASK = BYTE_W'(1) << WP_BIT;

    logic [BYTE_W-1:0] reg_q [NUM_REGS];

    assign wp = reg_q[CTRL_IDX][WP_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic host_hit;
        assign host_hit = wr_en && (wr_addr == IDX_W'(g));
        assign regs_flat[g*BYTE_W +: BYTE_W] = reg_q[g];

        if (g == CTRL_IDX) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        reg_q[g] <= rtc_pkg::reset_value(g);
                else if (host_hit) reg_q[g] <= wr_data & WP_MASK;
            end
        end else if (g < NUM_TIME) begin : g_time
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                reg_q[g] <= rtc_pkg::reset_value(g);
                else if (host_hit && !wp)  reg_q[g] <= wr_data;
                else if (ld_en)            reg_q[g] <= ld_time[g*BYTE_W +: BYTE_W];
            end
        end else begin : g_fixed
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) reg_q[g] <= rtc_pkg::reset_value(g);
            end
        end
    end
endmodule

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_pkg::*;
#(
    parameter int NUM_REGS = rtc_pkg::NUM_REGS,
    parameter int BYTE_W   = rtc_pkg::BYTE_W,
    parameter int ADDR_W   = rtc_pkg::ADDR_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(BYTE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_s,
    input  logic                       fall,
    input  logic [CNT_W-1:0]           bit_cnt,
    input  logic                       byte_done,
    input  logic [BYTE_W-1:0]          byte_val,
    input  logic [NUM_REGS*BYTE_W-1:0] regs_flat,
    output logic                       wr_en,
    output logic [IDX_W-1:0]           wr_addr,
    output logic [BYTE_W-1:0]          wr_data,
    output logic                       sdo,
    output logic                       sdo_oe,
    output xfer_state_e                state
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS-1);

    xfer_state_e       state_nx;
    logic              burst_q, valid_q, decode, advance;
    logic [IDX_W-1:0]  idx, idx_nx;
    logic [BYTE_W-1:0] cur_byte, sdo_r;
    logic [BYTE_W-1:0] snap [NUM_REGS];

    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_burst, cmd_valid, cmd_marker, cmd_read;
    logic [IDX_W-1:0]  cmd_start;

    assign cmd_marker = byte_val[BYTE_W-1];
    assign cmd_read   = byte_val[0];
    assign cmd_addr   = byte_val[ADDR_W:1];
    assign cmd_burst  = (cmd_addr == BURST_ADDR);
    assign cmd_valid  = cmd_burst || (cmd_addr < ADDR_W'(NUM_REGS));
    assign cmd_start  = cmd_burst ? '0 : cmd_addr[IDX_W-1:0];
    assign idx_nx     = idx + 1'b1;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and outputs.
    always_comb begin
        state_nx = state;
        wr_en    = 1'b0;
        wr_addr  = idx;
        wr_data  = byte_val;
        decode   = 1'b0;
        advance  = 1'b0;
        sdo_oe   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ce_s) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (!ce_s) begin
                    state_nx = ST_IDLE;
                end else if (byte_done) begin
                    decode = 1'b1;
                    if (!cmd_marker)   state_nx = ST_SKIP;
                    else if (cmd_read) state_nx = ST_RDATA;
                    else               state_nx = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (!ce_s) begin
                    state_nx = ST_IDLE;
                end else if (byte_done) begin
                    wr_en = valid_q;
                    if (burst_q && idx != LAST_IDX) advance  = 1'b1;
                    else                            state_nx = ST_SKIP;
                end
            end
            ST_RDATA: begin
                sdo_oe = 1'b1;
                if (!ce_s) begin
                    state_nx = ST_IDLE;
                end else if (byte_done) begin
                    if (burst_q && idx != LAST_IDX) advance  = 1'b1;
                    else                            state_nx = ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (!ce_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Command fields, snapshot and read shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q  <= 1'b0;
            valid_q  <= 1'b0;
            idx      <= '0;
            cur_byte <= '0;
            sdo_r    <= '0;
            for (int k = 0; k < NUM_REGS; k++) snap[k] <= '0;
        end else begin
            if (decode) begin
                burst_q <= cmd_burst;
                valid_q <= cmd_valid;
                idx     <= cmd_start;
                for (int k = 0; k < NUM_REGS; k++) snap[k] <= regs_flat[k*BYTE_W +: BYTE_W];
                cur_byte <= cmd_valid ? regs_flat[cmd_start*BYTE_W +: BYTE_W] : '0;
            end
            if (advance) begin
                idx      <= idx_nx;
                cur_byte <= snap[idx_nx];
            end
            if (state == ST_RDATA && fall) sdo_r <= {{(BYTE_W-1){1'b0}}, cur_byte[bit_cnt]};
            else if (state != ST_RDATA)    sdo_r <= '0;
        end
    end

    assign sdo = sdo_r[0];
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    input  logic                       ld_en,
    input  logic [NUM_TIME*BYTE_W-1:0] ld_time,
    output logic [NUM_TIME*BYTE_W-1:0] time_regs,
    output logic                       wp_out
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int CNT_W = $clog2(BYTE_W);

    logic                       ce_s, fall, byte_done, wr_en;
    logic [CNT_W-1:0]           bit_cnt;
    logic [BYTE_W-1:0]          byte_val, wr_data;
    logic [IDX_W-1:0]           wr_addr;
    logic [NUM_REGS*BYTE_W-1:0] regs_flat;
    xfer_state_e                fsm_state;

    rtc_serial_rx #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .ce_s(ce_s), .fall(fall), .bit_cnt(bit_cnt),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    rtc_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .fall(fall), .bit_cnt(bit_cnt),
        .byte_done(byte_done), .byte_val(byte_val), .regs_flat(regs_flat),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .state(fsm_state)
    );

    rtc_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ld_en(ld_en), .ld_time(ld_time),
        .regs_flat(regs_flat), .wp(wp_out)
    );

    assign time_regs = regs_flat[NUM_TIME*BYTE_W-1:0];
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ce_s,
    input logic [2:0]  state,
    input logic        sdo_oe,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        ld_en,
    input logic [55:0] ld_time,
    input logic        wp_out,
    input logic [55:0] time_regs
);
    logic [2:0]  wr_addr_q;
    logic [7:0]  wr_data_q;
    logic [63:0] padded;
    logic [7:0]  slot_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_addr_q <= wr_addr;
            wr_data_q <= wr_data;
        end
    end

    assign padded   = {8'h00, time_regs};
    assign slot_now = padded[wr_addr_q*8 +: 8];

    p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !sdo_oe);

    p_wp_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 3'd7 && wp_out && !ld_en) |=> $stable(time_regs));

    p_ctrl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd7) |=> (wp_out == $past(wr_data[7])));

    p_idle_on_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> (state == ST_IDLE));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !wr_en) |=> (time_regs == $past(ld_time)));

    p_host_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ld_en && wr_addr != 3'd7 && !wp_out) |=> (slot_now == wr_data_q));

    p_skip_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!wr_en && !sdo_oe));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .state(fsm_state), .sdo_oe(sdo_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ld_en(ld_en),
    .ld_time(ld_time), .wp_out(wp_out), .time_regs(time_regs)
);

// File: tb/tb_rtc_serial_slave.sv
`timescale 1ns/1ps
module tb_rtc_serial_slave;
    localparam int HALF = 8;
    localparam int NVEC = 24;
    // {req, cmd, data, expected read value}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd1,  8'h8F, 8'h00, 8'h80},  // R1 control reads protect set
        {4'd5,  8'h80, 8'h45, 8'h00},  // R5 blocked seconds write
        {4'd5,  8'h81, 8'h00, 8'h00},  // R5 seconds unchanged
        {4'd6,  8'h8E, 8'h00, 8'h00},  // R6 clear protect
        {4'd6,  8'h8F, 8'h00, 8'h00},
        {4'd4,  8'h80, 8'h45, 8'h00},  // R4 seconds
        {4'd4,  8'h81, 8'h00, 8'h45},
        {4'd4,  8'h82, 8'h59, 8'h00},  // R4 minutes
        {4'd4,  8'h83, 8'h00, 8'h59},
        {4'd4,  8'h8C, 8'h21, 8'h00},  // R4 year
        {4'd4,  8'h8D, 8'h00, 8'h21},
        {4'd6,  8'h8E, 8'h7F, 8'h00},  // R6 low bits dropped
        {4'd6,  8'h8F, 8'h00, 8'h00},
        {4'd6,  8'h8E, 8'hFF, 8'h00},
        {4'd6,  8'h8F, 8'h00, 8'h80},
        {4'd5,  8'h82, 8'h11, 8'h00},  // R5 blocked minutes write
        {4'd5,  8'h83, 8'h00, 8'h59},
        {4'd6,  8'h8E, 8'h00, 8'h00},
        {4'd11, 8'h91, 8'h00, 8'h00},  // R11 reserved address
        {4'd11, 8'h90, 8'hAA, 8'h00},
        {4'd11, 8'h91, 8'h00, 8'h00},
        {4'd11, 8'hC0, 8'h55, 8'h00},  // R11 storage area stub
        {4'd11, 8'hC1, 8'h00, 8'h00},
        {4'd1,  8'h8B, 8'h00, 8'h01}   // R1 weekday reset value
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0, ld_en = 1'b0;
    logic [55:0] ld_time = '0;
    logic        sdo, sdo_oe, wp_out;
    logic [55:0] time_regs;
    int          n_checks = 0, n_err = 0, oe_hits = 0;
    logic [7:0]  rb;
    logic [55:0] snap_exp;

    rtc_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .ld_en(ld_en), .ld_time(ld_time),
        .time_regs(time_regs), .wp_out(wp_out)
    );

    always #2.5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = b[i];
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        oe_hits = 0;
        for (int i = 0; i < 8; i++) begin
            tick(HALF);
            b[i] = sdo;
            if (sdo_oe) oe_hits++;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic open_xfer();
        ce = 1'b1;
        tick(HALF);
    endtask

    task automatic close_xfer();
        tick(HALF);
        ce = 1'b0;
        tick(4 * HALF);
    endtask

    task automatic write1(input logic [7:0] cmd, input logic [7:0] data);
        open_xfer();
        send_bits(cmd, 8);
        send_bits(data, 8);
        close_xfer();
    endtask

    task automatic read1(input logic [7:0] cmd, output logic [7:0] b);
        open_xfer();
        send_bits(cmd, 8);
        recv_byte(b);
        close_xfer();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [55:0] ld_a, ld_b, ld_c;
        logic [7:0]  bw [8];
        ld_a = 56'h99_07_12_31_23_58_57;
        ld_b = 56'h10_02_03_04_05_06_07;
        ld_c = 56'h42_04_05_06_07_08_09;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check_eq("R1", "time after reset", {8'h0, time_regs}, {8'h0, 56'h00_01_01_01_00_00_00});
        check_eq("R1", "protect after reset", {63'h0, wp_out}, 64'h1);
        check_eq("R3", "oe idle", {63'h0, sdo_oe}, 64'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            v = VEC[i];
            if (v[16]) begin
                read1(v[23:16], rb);
                check_eq($sformatf("R%0d", v[27:24]), $sformatf("vector %0d read", i), {56'h0, rb}, {56'h0, v[7:0]});
            end else begin
                write1(v[23:16], v[15:8]);
            end
        end
        check_eq("R4", "time after table", {8'h0, time_regs}, {8'h0, 56'h21_01_01_01_00_59_45});

        // R3 output enable high through the whole read byte
        read1(8'h81, rb);
        check_eq("R3", "oe samples during read", oe_hits, 8);

        // R7 burst write, control last sets protect
        bw = '{8'h30, 8'h15, 8'h12, 8'h25, 8'h06, 8'h03, 8'h24, 8'h80};
        open_xfer();
        send_bits(8'hBE, 8);
        for (int i = 0; i < 8; i++) send_bits(bw[i], 8);
        close_xfer();
        check_eq("R7", "time after burst write", {8'h0, time_regs}, {8'h0, 56'h24_03_06_25_12_15_30});
        check_eq("R7", "protect after burst write", {63'h0, wp_out}, 64'h1);

        // R5 burst under protect: time bytes dropped, control byte still lands
        bw = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h05, 8'h06, 8'h77, 8'h00};
        open_xfer();
        send_bits(8'hBE, 8);
        for (int i = 0; i < 8; i++) send_bits(bw[i], 8);
        close_xfer();
        check_eq("R5", "time after protected burst", {8'h0, time_regs}, {8'h0, 56'h24_03_06_25_12_15_30});
        check_eq("R7", "protect cleared by last byte", {63'h0, wp_out}, 64'h0);

        // R8 burst read from snapshot while the load port changes the bank
        snap_exp = 56'h24_03_06_25_12_15_30;
        open_xfer();
        send_bits(8'hBF, 8);
        for (int i = 0; i < 8; i++) begin
            recv_byte(rb);
            if (i == 0) begin
                ld_time = ld_a;
                ld_en = 1'b1;
                tick(1);
                ld_en = 1'b0;
            end
            if (i < 7) check_eq("R8", $sformatf("burst byte %0d", i), {56'h0, rb}, {56'h0, snap_exp[i*8 +: 8]});
            else       check_eq("R8", "burst control byte", {56'h0, rb}, 64'h0);
        end
        close_xfer();
        check_eq("R10", "load applied", {8'h0, time_regs}, {8'h0, ld_a});

        // R8 burst read cut after seven bytes
        open_xfer();
        send_bits(8'hBF, 8);
        for (int i = 0; i < 7; i++) recv_byte(rb);
        check_eq("R8", "seventh byte of short burst", {56'h0, rb}, 64'h99);
        close_xfer();

        // R9 abort mid-command, then a fresh read
        open_xfer();
        send_bits(8'h81, 5);
        close_xfer();
        read1(8'h81, rb);
        check_eq("R9", "read after aborted command", {56'h0, rb}, 64'h57);

        // R9 abort mid-data discards partial byte
        open_xfer();
        send_bits(8'h80, 8);
        send_bits(8'h0F, 4);
        close_xfer();
        check_eq("R9", "seconds after aborted write", {56'h0, time_regs[7:0]}, 64'h57);
        write1(8'h80, 8'h33);
        check_eq("R9", "seconds after fresh write", {56'h0, time_regs[7:0]}, 64'h33);

        // R2 command without marker bit
        write1(8'h00, 8'h77);
        check_eq("R2", "seconds after unmarked write", {56'h0, time_regs[7:0]}, 64'h33);
        read1(8'h01, rb);
        check_eq("R2", "oe after unmarked read", oe_hits, 0);

        // R12 extra clocks after single transfers
        open_xfer();
        send_bits(8'h80, 8);
        send_bits(8'h12, 8);
        send_bits(8'h34, 8);
        close_xfer();
        check_eq("R12", "seconds after extra byte", {56'h0, time_regs[7:0]}, 64'h12);
        open_xfer();
        send_bits(8'h81, 8);
        recv_byte(rb);
        check_eq("R3", "single read value", {56'h0, rb}, 64'h12);
        recv_byte(rb);
        check_eq("R12", "oe after read byte", oe_hits, 0);
        close_xfer();

        // R10 load held across a host write; load persists afterwards
        ld_time = ld_b;
        ld_en = 1'b1;
        write1(8'h80, 8'h44);
        ld_en = 1'b0;
        tick(2);
        check_eq("R10", "load held over write", {8'h0, time_regs}, {8'h0, ld_b});

        // R10 load ignores protect
        write1(8'h8E, 8'h80);
        ld_time = ld_c;
        ld_en = 1'b1;
        tick(1);
        ld_en = 1'b0;
        tick(2);
        check_eq("R10", "load under protect", {8'h0, time_regs}, {8'h0, ld_c});
        check_eq("R6", "protect set again", {63'h0, wp_out}, 64'h1);

        finish_run();
    end
endmodule